// File: doc/BRIEF.md
# Fixed-Latency Pulse Delay Line

This block holds back a one-bit event stream by a constant number of clock cycles, fixed when the block is built. Any pattern of events comes out unchanged, including events on every cycle. Each event appears on the output exactly `DELAY` cycles after it entered. A second output reports whether any accepted event is still waiting inside the line.

The line is built as a bit vector with one slot per cycle of latency. A write pointer moves one slot forward each cycle and wraps back to zero after the last slot. In each cycle the slot under the pointer is first read to produce the output, and the new input bit is then stored in that same slot. As a result, the work done per cycle stays the same however large `DELAY` is. A latency of one cycle is built as a single flip-flop, and a latency of zero is a plain wire.

A synchronous flush input discards every event held in the line. Synchronous reset has the same effect on the stored events and also returns the pointer to slot zero.

Top module: `pulse_delay`

## Requirements
- R1: For DELAY of 2 or more, an event accepted in cycle t (trig_in high with clear and rst low) drives trig_out high in cycle t+DELAY for exactly one cycle. Each event on consecutive cycles emerges separately and in the same order.
- R2: The storage is DELAY bits plus a write pointer that steps forward by one every cycle and wraps from DELAY-1 to 0. The slot due for output is read in the same cycle that it is rewritten, so a line that is full on every cycle loses no event.
- R3: pending is high in cycle t exactly when at least one event accepted in cycles t-DELAY to t-1 has not been flushed. trig_out is never high while pending is low.
- R4: When clear is high in cycle t, the event offered in cycle t is dropped. Every held event is gone from cycle t+1 onward. trig_out in cycle t still shows the event that was due in that cycle. The pointer keeps stepping, so events accepted after the flush emerge exactly DELAY cycles later.
- R5: Synchronous reset empties the line and sets the pointer to 0. In the first cycle after reset, trig_out and pending are low.
- R6: With DELAY equal to 1, trig_out is the accepted event from the previous cycle, and pending equals trig_out.
- R7: With DELAY equal to 0, trig_out equals trig_in in the same cycle, even during clear or reset, and pending stays low.
- R8: A DELAY of 1024 meets R1 to R4, including runs of back-to-back events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| trig_in | input | 1 | Event to be delayed |
| clear | input | 1 | Synchronous flush of all held events |
| trig_out | output | 1 | Event delayed by DELAY cycles |
| pending | output | 1 | High while any accepted event is held in the line |

## Verification
Five copies of the line are driven from the same stimulus, with DELAY set to 0, 1, 2, 7 and 1024.

- **Single isolated event:** shows whether the latency is exact for each depth.
- **Run of back-to-back events:** longer than the small depths, so it catches a pointer that fails to wrap and a write that overwrites a slot before it is read.
- **Dense events with flushes:** flushes fall in the middle of the traffic, some on a cycle that also carries an event. This separates three things: dropping the event in the flush cycle, the output in the flush cycle itself, and timing after the flush when the pointer has kept moving.
- **Long random stream with rare flushes, then a mid-stream reset:** compared cycle by cycle against a history-based model of both outputs. This also confirms that the zero-latency wire ignores reset.

// File: rtl/pulse_delay_pkg.sv
package pulse_delay_pkg;

  // Pointer step with wrap: the slot after the last one is slot zero.
  function automatic int unsigned pd_step_slot(input int unsigned slot,
                                               input int unsigned depth);
    return (slot == depth - 1) ? 0 : slot + 1;
  endfunction

  // Pointer width for a ring of the given depth (at least one bit).
  function automatic int unsigned pd_slot_bits(input int unsigned depth);
    return (depth > 2) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/pulse_delay_ring.sv
module pulse_delay_ring
  import pulse_delay_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_in,
  input  logic clear,
  output logic trig_out,
  output logic pending
);
  localparam int unsigned SW = pd_slot_bits(DEPTH);
  localparam logic [SW-1:0] LAST_SLOT = SW'(DEPTH - 1);

  logic [DEPTH-1:0] slots;
  logic [SW-1:0]    wr_slot;
  logic [SW-1:0]    wr_slot_nxt;
  logic             slot_due;
  logic             accept;

  assign wr_slot_nxt = SW'(pd_step_slot(32'(wr_slot), DEPTH));
  assign slot_due    = slots[wr_slot];
  assign accept      = trig_in && !clear;
  assign trig_out    = slot_due;
  assign pending     = |slots;

  always_ff @(posedge clk) begin
    if (rst) begin
      slots   <= '0;
      wr_slot <= '0;
    end else begin
      if (clear) slots <= '0;
      else       slots[wr_slot] <= trig_in;
      wr_slot <= wr_slot_nxt;
    end
  end

  // R2: pointer stays inside the ring and wraps after the last slot
  assert_slot_bound_R2: assert property (@(posedge clk) disable iff (rst)
    32'(wr_slot) < DEPTH);
  assert_slot_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_slot == LAST_SLOT) |=> (wr_slot == '0));
  // R3: an accepted event is visible as pending on the next cycle
  assert_accept_pending_R3: assert property (@(posedge clk) disable iff (rst)
    accept |=> pending);
  assert_quiet_line_R3: assert property (@(posedge clk) disable iff (rst)
    !pending |-> !trig_out);
  // R4: a flush leaves nothing held
  assert_flush_empties_R4: assert property (@(posedge clk) disable iff (rst)
    clear |=> !pending);
endmodule

// File: rtl/pulse_delay_flop.sv
module pulse_delay_flop (
  input  logic clk,
  input  logic rst,
  input  logic trig_in,
  input  logic clear,
  output logic trig_out,
  output logic pending
);
  logic held;

  always_ff @(posedge clk) begin
    if (rst || clear) held <= 1'b0;
    else              held <= trig_in;
  end

  assign trig_out = held;
  assign pending  = held;

  // R6: an accepted event shows one cycle later; a flushed one does not
  assert_flop_pass_R6: assert property (@(posedge clk) disable iff (rst)
    (trig_in && !clear) |=> trig_out);
  assert_flop_drop_R6: assert property (@(posedge clk) disable iff (rst)
    clear |=> !trig_out);
endmodule

// File: rtl/pulse_delay.sv
module pulse_delay #(
  parameter int unsigned DELAY = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_in,
  input  logic clear,
  output logic trig_out,
  output logic pending
);
  generate
    if (DELAY == 0) begin : g_wire
      assign trig_out = trig_in;
      assign pending  = 1'b0;
    end else if (DELAY == 1) begin : g_flop
      pulse_delay_flop u_flop (
        .clk(clk), .rst(rst), .trig_in(trig_in), .clear(clear),
        .trig_out(trig_out), .pending(pending)
      );
    end else begin : g_ring
      pulse_delay_ring #(.DEPTH(DELAY)) u_ring (
        .clk(clk), .rst(rst), .trig_in(trig_in), .clear(clear),
        .trig_out(trig_out), .pending(pending)
      );
    end
  endgenerate

  // R3: output only fires while the line holds something (DELAY > 0)
  assert_out_needs_pending_R3: assert property (@(posedge clk) disable iff (rst)
    (DELAY != 0 && trig_out) |-> pending);
endmodule

// File: tb/pulse_delay_test.sv
module pulse_delay_test;
  localparam int NV = 5;
  localparam int DL[NV] = '{1024, 0, 1, 2, 7};
  localparam int HMAX = 8192;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig = 1'b0;
  logic clr = 1'b0;
  logic [NV-1:0] outs;
  logic [NV-1:0] pends;

  always #10 clk = ~clk;

  pulse_delay #(.DELAY(1024)) uut (.clk(clk), .rst(rst), .trig_in(trig), .clear(clr),
    .trig_out(outs[0]), .pending(pends[0]));
  pulse_delay #(.DELAY(0)) uut_d0 (.clk(clk), .rst(rst), .trig_in(trig), .clear(clr),
    .trig_out(outs[1]), .pending(pends[1]));
  pulse_delay #(.DELAY(1)) uut_d1 (.clk(clk), .rst(rst), .trig_in(trig), .clear(clr),
    .trig_out(outs[2]), .pending(pends[2]));
  pulse_delay #(.DELAY(2)) uut_d2 (.clk(clk), .rst(rst), .trig_in(trig), .clear(clr),
    .trig_out(outs[3]), .pending(pends[3]));
  pulse_delay #(.DELAY(7)) uut_d7 (.clk(clk), .rst(rst), .trig_in(trig), .clear(clr),
    .trig_out(outs[4]), .pending(pends[4]));

  int checks = 0;
  int fails = 0;
  int t = 0;
  bit done = 0;
  bit acc_h[HMAX];
  int flush_sum[HMAX];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, t, act, exp);
    end
  endtask

  function automatic bit survives(input int k);
    return acc_h[k] && (flush_sum[t-1] == flush_sum[k]);
  endfunction

  function automatic bit exp_out(input int n);
    if (n == 0) return trig;
    if (t - n < 0) return 1'b0;
    return survives(t - n);
  endfunction

  function automatic bit exp_pend(input int n);
    if (n == 0) return 1'b0;
    for (int k = (t - n < 0) ? 0 : t - n; k < t; k++)
      if (survives(k)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic string tag_for(input int n, input string tag);
    if (tag != "") return tag;
    if (n == 0) return "R7";
    if (n == 1) return "R6";
    if (n == 1024) return "R8";
    return "R1";
  endfunction

  // One clock cycle: drive, check, record, advance.
  task automatic cycle(input bit tr, input bit cl, input string tag);
    trig = tr;
    clr = cl;
    #1;
    for (int v = 0; v < NV; v++) begin
      if (!rst) begin
        chk(outs[v] == exp_out(DL[v]), tag_for(DL[v], tag), outs[v], exp_out(DL[v]));
        chk(pends[v] == exp_pend(DL[v]), (DL[v] == 0) ? "R7" : "R3", pends[v], exp_pend(DL[v]));
      end else if (DL[v] == 0) begin
        chk(outs[v] == trig, "R7", outs[v], trig);
      end
    end
    acc_h[t] = tr && !cl && !rst;
    flush_sum[t] = ((t > 0) ? flush_sum[t-1] : 0) + ((cl || rst) ? 1 : 0);
    @(posedge clk);
    @(negedge clk);
    t++;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, tag);
  endtask

  task automatic t_reset_state();
    rst = 1'b1;
    cycle(1'b1, 1'b0, "R5");
    cycle(1'b0, 1'b0, "R5");
    rst = 1'b0;
    #1;
    for (int v = 1; v < NV; v++) begin
      if (DL[v] != 0) begin
        chk(outs[v] == 1'b0, "R5", outs[v], 0);
        chk(pends[v] == 1'b0, "R5", pends[v], 0);
      end
    end
    chk(outs[0] == 1'b0 && pends[0] == 1'b0, "R5", {outs[0], pends[0]}, 0);
    cycle(1'b0, 1'b0, "R5");
  endtask

  task automatic t_single();
    cycle(1'b1, 1'b0, "");
    idle(1030, "");
  endtask

  task automatic t_back_to_back();
    for (int i = 0; i < 12; i++) cycle(1'b1, 1'b0, "R2");
    idle(1030, "R2");
  endtask

  task automatic t_flush();
    for (int i = 0; i < 20; i++) cycle(i % 3 != 2, (i == 9) || (i == 15), "R4");
    cycle(1'b1, 1'b1, "R4");
    for (int i = 0; i < 10; i++) cycle(1'b1, 1'b0, "R4");
    idle(1030, "R4");
  endtask

  task automatic t_random();
    for (int i = 0; i < 1500; i++)
      cycle(1'($urandom_range(0, 1)), ($urandom_range(0, 63) == 0), "");
    idle(20, "");
  endtask

  task automatic t_mid_reset();
    for (int i = 0; i < 30; i++) cycle(1'($urandom_range(0, 1)), 1'b0, "");
    rst = 1'b1;
    cycle(1'b1, 1'b0, "R5");
    cycle(1'b0, 1'b0, "R5");
    rst = 1'b0;
    for (int i = 0; i < 10; i++) cycle(i[0], 1'b0, "R5");
    idle(20, "R5");
  endtask

  initial begin
    @(negedge clk);
    t_reset_state();
    t_single();
    t_back_to_back();
    t_flush();
    t_random();
    t_mid_reset();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(64'd200000 * 64'd20);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule